// File: doc/BRIEF.md
# Receive Ring Buffer Frame Writer

This block stores incoming network frames into a circular receive area made of 256-byte pages. Software sets the first and the one-past-last page of the area and a boundary page marking how far it has read. The block owns the current page, which is where the next frame goes. When the first byte of a frame arrives, the block decides from the page registers whether a maximum-size frame would still fit. If it would, the block writes a 4-byte descriptor at the start of the current page, then the frame bytes, then zero fill for short frames. Writes wrap from the end of the area back to its first page.

When the last byte is written, the current page moves to the page after the frame and a sticky frame-received flag is raised for the interrupt logic. A frame that arrives while the receiver is stopped, or that finds too little room, is still taken from the input but nothing is written. Frames come in as a byte stream with valid/ready handshaking. The first byte is marked and carries the frame length alongside it.

Top module: `rxr_ring_writer`

## Requirements
- R1: While `stopped` is high when a first byte is taken, the frame is discarded: no memory write, `cur_pg` and `rx_flag` unchanged.
- R2: Free bytes are `(bound_pg - cur_pg)*256` when `cur_pg < bound_pg`, otherwise `ring size - (cur_pg - bound_pg)*256`, where ring size is `(ring_stop_pg - ring_start_pg)*256`. The frame is dropped when free bytes are below MAX_FRAME+4 (1518 by default).
- R3: A frame shorter than MIN_FRAME (60) bytes is stored followed by zero bytes up to MIN_FRAME bytes.
- R4: The descriptor occupies `cur_pg*256` to `cur_pg*256+3`. Byte 0 is the status, byte 1 the next page, and bytes 2 and 3 the stored length (padded length + 4), low byte first.
- R5: In the status byte, bit 0 is always 1 and bit 5 equals bit 0 of the frame's first byte. All other bits are 0.
- R6: The next page is `cur_pg + ceil((stored length + 4)/256)`. If that reaches or passes `ring_stop_pg`, the ring size in pages is subtracted.
- R7: Frame bytes follow the descriptor at consecutive addresses. An address equal to `ring_stop_pg*256` is replaced by `ring_start_pg*256`.
- R8: In the cycle after the last write of a stored frame, `cur_pg` equals the next page and `rx_flag` is 1.
- R9: `rx_flag` stays set until `rx_clr` is pulsed. A frame completion in the same cycle wins over `rx_clr`.
- R10: `in_ready` is low while the descriptor is written. A byte offered in idle without `in_first` is taken and ignored.
- R11: All remaining bytes of a dropped frame are taken with `in_ready` high and cause no write.
- R12: `cur_wr_en` loads `cur_wr_pg` into `cur_pg` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stopped | input | 1 | Receiver stop control |
| ring_start_pg | input | 8 | First page of the ring |
| ring_stop_pg | input | 8 | Page one past the ring |
| bound_pg | input | 8 | Software read boundary page |
| cur_wr_en | input | 1 | Load strobe for the current page |
| cur_wr_pg | input | 8 | Value loaded into the current page |
| rx_clr | input | 1 | Clears the frame-received flag |
| in_valid | input | 1 | Input byte valid |
| in_first | input | 1 | Marks the first byte of a frame |
| in_len | input | LEN_W | Frame length, qualified by `in_first` |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Block can take an input byte |
| cur_pg | output | 8 | Current page (write point) |
| rx_flag | output | 1 | Sticky frame-received flag |
| mem_we | output | 1 | Buffer RAM write enable |
| mem_addr | output | 16 | Buffer RAM byte address |
| mem_wdata | output | 8 | Buffer RAM write data |

## Verification
The bench uses the default parameters: LEN_W 11, MAX_FRAME 1514, MIN_FRAME 60. It programs a ring of only eight pages, 0x04 to 0x0C. With a ring this small, the space check reaches both outcomes from a few page settings, and a 600-byte frame wraps its payload from page 0x0B into page 0x04. A full 1514-byte frame lands its next page exactly on the stop page, so the next page wraps to the start. Frame lengths of 248 and 249 bytes sit on either side of the point where the 4 reserved CRC bytes push the next page one page further.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int PG_W       = 8;
    localparam int ADDR_W     = PG_W + 8;
    localparam int PAGE_BYTES = 256;
    localparam int HDR_BYTES  = 4;
    localparam int CRC_ROOM   = 4;
    localparam int ST_OK_BIT  = 0;
    localparam int ST_MC_BIT  = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_HEAD,
        S_BODY,
        S_PAD,
        S_SKIP
    } wr_state_e;

    typedef struct packed {
        logic [7:0]  status;
        logic [7:0]  next_pg;
        logic [15:0] total_len;
    } rx_hdr_t;

    function automatic logic [7:0] make_status(input logic dst0);
        logic [7:0] s;
        s = '0;
        s[ST_OK_BIT] = 1'b1;
        s[ST_MC_BIT] = dst0;
        return s;
    endfunction

    function automatic logic [7:0] hdr_byte(input rx_hdr_t h, input logic [1:0] sel);
        case (sel)
            2'd0:    return h.status;
            2'd1:    return h.next_pg;
            2'd2:    return h.total_len[7:0];
            default: return h.total_len[15:8];
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] page_base(input logic [PG_W-1:0] pg);
        return {pg, 8'h00};
    endfunction

endpackage

// File: rtl/rxr_admit.sv
module rxr_admit
    import rxr_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60
) (
    input  logic             stopped,
    input  logic [PG_W-1:0]  start_pg,
    input  logic [PG_W-1:0]  stop_pg,
    input  logic [PG_W-1:0]  bound_pg,
    input  logic [PG_W-1:0]  cur_pg,
    input  logic [LEN_W-1:0] in_len,
    input  logic             dst0,
    output logic             accept,
    output logic [15:0]      pad_len,
    output rx_hdr_t          hdr
);
    localparam int SW = ADDR_W + 2;
    localparam logic signed [SW-1:0] NEED = SW'(MAX_FRAME + HDR_BYTES);

    logic signed [SW-1:0] pos_b, bnd_b, ring_b, free_b;
    logic [15:0]          len16, total;
    logic [ADDR_W:0]      span_b;
    logic [PG_W:0]        raw_pg;
    logic [PG_W-1:0]      ring_pg;
    logic                 wrap;

    always_comb begin
        // free space in bytes between write point and read boundary
        pos_b  = $signed({2'b00, page_base(cur_pg)});
        bnd_b  = $signed({2'b00, page_base(bound_pg)});
        ring_b = $signed({2'b00, page_base(stop_pg)}) - $signed({2'b00, page_base(start_pg)});
        if (pos_b < bnd_b)
            free_b = bnd_b - pos_b;
        else
            free_b = ring_b - (pos_b - bnd_b);
        accept = !stopped && (free_b >= NEED);

        // padded and stored lengths
        len16   = 16'(in_len);
        pad_len = (len16 < 16'(MIN_FRAME)) ? 16'(MIN_FRAME) : len16;
        total   = pad_len + 16'(HDR_BYTES);

        // whole pages including CRC room, then ring wrap
        span_b  = {1'b0, total} + (ADDR_W+1)'(CRC_ROOM + PAGE_BYTES - 1);
        raw_pg  = {1'b0, cur_pg} + (PG_W+1)'(span_b >> 8);
        ring_pg = stop_pg - start_pg;
        wrap    = raw_pg >= {1'b0, stop_pg};

        hdr.status    = make_status(dst0);
        hdr.next_pg   = raw_pg[PG_W-1:0] - (wrap ? ring_pg : '0);
        hdr.total_len = total;
    end

endmodule

// File: rtl/rxr_addr_gen.sv
module rxr_addr_gen
    import rxr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PG_W-1:0]   load_pg,
    input  logic              step,
    input  logic [PG_W-1:0]   start_pg,
    input  logic [PG_W-1:0]   stop_pg,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] inc;

    always_comb begin
        inc = addr + 1'b1;
        if (inc == page_base(stop_pg))
            inc = page_base(start_pg);
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= page_base(load_pg);
        else if (step)
            addr <= inc;
    end

endmodule

// File: rtl/rxr_seq.sv
module rxr_seq
    import rxr_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic [LEN_W-1:0] in_len,
    input  logic [7:0]       in_data,
    input  logic             accept,
    input  logic [15:0]      pad_len,
    input  rx_hdr_t          hdr_in,
    output logic             in_ready,
    output logic             mem_we,
    output logic [7:0]       mem_wdata,
    output logic             addr_load,
    output logic             addr_step,
    output logic             frame_done,
    output logic [PG_W-1:0]  commit_pg
);
    wr_state_e   state;
    rx_hdr_t     hdr_q;
    logic [7:0]  hold_q;
    logic [1:0]  hsel;
    logic [15:0] in_left;
    logic [15:0] wr_left;
    logic [15:0] len16;
    logic        take;

    assign len16     = 16'(in_len);
    assign take      = (state == S_IDLE) && in_valid && in_first;
    assign addr_load = take && accept;
    assign commit_pg = hdr_q.next_pg;

    always_comb begin
        in_ready   = 1'b0;
        mem_we     = 1'b0;
        mem_wdata  = 8'h00;
        frame_done = 1'b0;
        case (state)
            S_IDLE: in_ready = 1'b1;
            S_HDR: begin
                mem_we    = 1'b1;
                mem_wdata = hdr_byte(hdr_q, hsel);
            end
            S_HEAD: begin
                mem_we     = 1'b1;
                mem_wdata  = hold_q;
                frame_done = (wr_left == 16'd0);
            end
            S_BODY: begin
                in_ready   = 1'b1;
                mem_we     = in_valid;
                mem_wdata  = in_data;
                frame_done = in_valid && (in_left == 16'd1) && (wr_left == 16'd1);
            end
            S_PAD: begin
                mem_we     = 1'b1;
                frame_done = (wr_left == 16'd1);
            end
            S_SKIP: in_ready = 1'b1;
            default: ;
        endcase
    end

    assign addr_step = mem_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            hdr_q   <= '0;
            hold_q  <= '0;
            hsel    <= '0;
            in_left <= '0;
            wr_left <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (take) begin
                        hdr_q   <= hdr_in;
                        hold_q  <= in_data;
                        hsel    <= '0;
                        in_left <= (len16 == 16'd0) ? 16'd0 : len16 - 16'd1;
                        wr_left <= pad_len - 16'd1;
                        if (accept)
                            state <= S_HDR;
                        else if (len16 > 16'd1)
                            state <= S_SKIP;
                    end
                end
                S_HDR: begin
                    hsel <= hsel + 2'd1;
                    if (hsel == 2'd3)
                        state <= S_HEAD;
                end
                S_HEAD: begin
                    if (wr_left == 16'd0)
                        state <= S_IDLE;
                    else if (in_left != 16'd0)
                        state <= S_BODY;
                    else
                        state <= S_PAD;
                end
                S_BODY: begin
                    if (in_valid) begin
                        in_left <= in_left - 16'd1;
                        wr_left <= wr_left - 16'd1;
                        if (in_left == 16'd1)
                            state <= (wr_left == 16'd1) ? S_IDLE : S_PAD;
                    end
                end
                S_PAD: begin
                    wr_left <= wr_left - 16'd1;
                    if (wr_left == 16'd1)
                        state <= S_IDLE;
                end
                S_SKIP: begin
                    if (in_valid) begin
                        in_left <= in_left - 16'd1;
                        if (in_left == 16'd1)
                            state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stopped,
    input  logic [PG_W-1:0]   ring_start_pg,
    input  logic [PG_W-1:0]   ring_stop_pg,
    input  logic [PG_W-1:0]   bound_pg,
    input  logic              cur_wr_en,
    input  logic [PG_W-1:0]   cur_wr_pg,
    input  logic              rx_clr,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic [PG_W-1:0]   cur_pg,
    output logic              rx_flag,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    logic            accept;
    logic [15:0]     pad_len;
    rx_hdr_t         hdr;
    logic            addr_load, addr_step, frame_done;
    logic [PG_W-1:0] commit_pg;

    rxr_admit #(
        .LEN_W     (LEN_W),
        .MAX_FRAME (MAX_FRAME),
        .MIN_FRAME (MIN_FRAME)
    ) u_admit (
        .stopped  (stopped),
        .start_pg (ring_start_pg),
        .stop_pg  (ring_stop_pg),
        .bound_pg (bound_pg),
        .cur_pg   (cur_pg),
        .in_len   (in_len),
        .dst0     (in_data[0]),
        .accept   (accept),
        .pad_len  (pad_len),
        .hdr      (hdr)
    );

    rxr_seq #(
        .LEN_W (LEN_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_first   (in_first),
        .in_len     (in_len),
        .in_data    (in_data),
        .accept     (accept),
        .pad_len    (pad_len),
        .hdr_in     (hdr),
        .in_ready   (in_ready),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .addr_load  (addr_load),
        .addr_step  (addr_step),
        .frame_done (frame_done),
        .commit_pg  (commit_pg)
    );

    rxr_addr_gen u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (addr_load),
        .load_pg  (cur_pg),
        .step     (addr_step),
        .start_pg (ring_start_pg),
        .stop_pg  (ring_stop_pg),
        .addr     (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_pg  <= '0;
            rx_flag <= 1'b0;
        end else begin
            if (frame_done)
                cur_pg <= commit_pg;
            else if (cur_wr_en)
                cur_pg <= cur_wr_pg;

            if (frame_done)
                rx_flag <= 1'b1;
            else if (rx_clr)
                rx_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk
    import rxr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              stopped,
    input logic [PG_W-1:0]   ring_start_pg,
    input logic [PG_W-1:0]   ring_stop_pg,
    input logic              cur_wr_en,
    input logic              rx_clr,
    input logic              in_valid,
    input logic              in_first,
    input logic              in_ready,
    input logic [PG_W-1:0]   cur_pg,
    input logic              rx_flag,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    // R7: every write lands inside the ring
    p_ring_bounds_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr >= page_base(ring_start_pg)) && (mem_addr < page_base(ring_stop_pg)));

    // R7: back-to-back writes step by one or wrap to the ring start
    p_addr_seq_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |->
            ((mem_addr == ADDR_W'($past(mem_addr) + 1'b1)) ||
             ((mem_addr == page_base(ring_start_pg)) &&
              (ADDR_W'($past(mem_addr) + 1'b1) == page_base(ring_stop_pg)))));

    // R1: a frame opened while stopped produces no write
    p_stop_nowrite_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_first && stopped && !mem_we) |=> !mem_we);

    // R9: the received flag holds until cleared
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_flag && !rx_clr) |=> rx_flag);

    // R8: without a host load, the current page only moves at a completion
    p_cur_move_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(cur_wr_en) && (cur_pg != $past(cur_pg))) |-> rx_flag);

endmodule

bind rxr_ring_writer rxr_ring_writer_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .stopped       (stopped),
    .ring_start_pg (ring_start_pg),
    .ring_stop_pg  (ring_stop_pg),
    .cur_wr_en     (cur_wr_en),
    .rx_clr        (rx_clr),
    .in_valid      (in_valid),
    .in_first      (in_first),
    .in_ready      (in_ready),
    .cur_pg        (cur_pg),
    .rx_flag       (rx_flag),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr)
);

// File: tb/rxr_ring_writer_bench.sv
`timescale 1ns/1ps
module rxr_ring_writer_bench;
    localparam int LEN_W = 11;
    localparam int START = 8'h04;
    localparam int STOP  = 8'h0C;
    localparam int NV    = 12;

    // {cur 8, bound 8, len 16, first byte 8, accept 1, next page 8}
    localparam logic [48:0] VEC [0:NV-1] = '{
        {8'h04, 8'h04, 16'd20,   8'h00, 1'b1, 8'h05},
        {8'h05, 8'h04, 16'd300,  8'h01, 1'b1, 8'h07},
        {8'h0B, 8'h0A, 16'd600,  8'h02, 1'b1, 8'h06},
        {8'h04, 8'h06, 16'd100,  8'h00, 1'b0, 8'h04},
        {8'h06, 8'h06, 16'd60,   8'hFF, 1'b1, 8'h07},
        {8'h09, 8'h04, 16'd100,  8'h00, 1'b0, 8'h09},
        {8'h07, 8'h04, 16'd100,  8'h00, 1'b0, 8'h07},
        {8'h06, 8'h04, 16'd1514, 8'h03, 1'b1, 8'h04},
        {8'h04, 8'h04, 16'd248,  8'h00, 1'b1, 8'h05},
        {8'h04, 8'h04, 16'd249,  8'h00, 1'b1, 8'h06},
        {8'h04, 8'h04, 16'd59,   8'h01, 1'b1, 8'h05},
        {8'h04, 8'h04, 16'd1,    8'h00, 1'b1, 8'h05}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst = 1'b1;
    logic             stopped = 1'b0;
    logic [7:0]       ring_start_pg = 8'(START);
    logic [7:0]       ring_stop_pg  = 8'(STOP);
    logic [7:0]       bound_pg = 8'h04;
    logic             cur_wr_en = 1'b0;
    logic [7:0]       cur_wr_pg = 8'h00;
    logic             rx_clr = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_first = 1'b0;
    logic [LEN_W-1:0] in_len = '0;
    logic [7:0]       in_data = 8'h00;
    logic             in_ready;
    logic [7:0]       cur_pg;
    logic             rx_flag;
    logic             mem_we;
    logic [15:0]      mem_addr;
    logic [7:0]       mem_wdata;

    int n_chk  = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    bit fill   = 1'b0;
    logic [7:0] bmem [0:4095];

    rxr_ring_writer #(.LEN_W(LEN_W)) u_rxr_ring_writer (
        .clk(clk), .rst(rst), .stopped(stopped),
        .ring_start_pg(ring_start_pg), .ring_stop_pg(ring_stop_pg), .bound_pg(bound_pg),
        .cur_wr_en(cur_wr_en), .cur_wr_pg(cur_wr_pg), .rx_clr(rx_clr),
        .in_valid(in_valid), .in_first(in_first), .in_len(in_len), .in_data(in_data),
        .in_ready(in_ready), .cur_pg(cur_pg), .rx_flag(rx_flag),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < 4096; i++) bmem[i] = 8'hA5;
        end else if (mem_we) begin
            bmem[mem_addr[11:0]] = mem_wdata;
            wr_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input int k, input int seed);
        return 8'(((k * 13 + seed * 7) % 255) + 1);
    endfunction

    function automatic int ring_inc(input int a);
        return (a + 1 == STOP * 256) ? START * 256 : a + 1;
    endfunction

    // called at a negative edge; returns in_ready seen after the first byte
    task automatic send_frame(input int len, input logic [7:0] dst, input int seed,
                              output bit rdy_after_first);
        bit r;
        rdy_after_first = 1'b0;
        for (int k = 0; k < len; k++) begin
            in_valid = 1'b1;
            in_first = (k == 0);
            in_len   = LEN_W'(len);
            in_data  = (k == 0) ? dst : pay(k, seed);
            forever begin
                r = in_ready;
                @(posedge clk);
                @(negedge clk);
                if (r) break;
            end
            if (k == 0) rdy_after_first = in_ready;
        end
        in_valid = 1'b0;
        in_first = 1'b0;
        while (mem_we) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_regs(input logic [7:0] c, input logic [7:0] b);
        cur_wr_en = 1'b1;
        cur_wr_pg = c;
        bound_pg  = b;
        rx_clr    = 1'b1;
        @(negedge clk);
        cur_wr_en = 1'b0;
        rx_clr    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit rdy1;
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk(cur_pg == 8'h00, "reset cur_pg", cur_pg, 0);
        chk(rx_flag == 1'b0, "reset rx_flag", rx_flag, 0);
        chk(mem_we == 1'b0, "reset mem_we", mem_we, 0);
        chk(in_ready == 1'b1, "reset in_ready", in_ready, 1);

        // R12: host load of the current page
        set_regs(8'h07, 8'h04);
        chk(cur_pg == 8'h07, "R12 host load", cur_pg, 8'h07);

        // R10: stray byte in idle is taken and ignored
        base = wr_cnt;
        in_valid = 1'b1; in_first = 1'b0; in_data = 8'h33; in_len = LEN_W'(10);
        chk(in_ready == 1'b1, "R10 stray ready", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(wr_cnt == base, "R10 stray writes", wr_cnt - base, 0);
        chk(cur_pg == 8'h07 && !rx_flag, "R10 stray state", cur_pg, 8'h07);

        // R1: stopped receiver stores nothing
        set_regs(8'h04, 8'h04);
        stopped = 1'b1;
        base = wr_cnt;
        send_frame(80, 8'h00, 99, rdy1);
        stopped = 1'b0;
        chk(wr_cnt == base, "R1 writes", wr_cnt - base, 0);
        chk(cur_pg == 8'h04, "R1 cur_pg", cur_pg, 8'h04);
        chk(rx_flag == 1'b0, "R1 rx_flag", rx_flag, 0);

        // table of frames
        for (int v = 0; v < NV; v++) begin
            logic [7:0]  c, b, dst, nx;
            int          len, padl, tot, a;
            bit          acc;
            logic [7:0]  hexp [0:3];
            logic [7:0]  e;
            {c, b} = VEC[v][48:33];
            len    = int'(VEC[v][32:17]);
            dst    = VEC[v][16:9];
            acc    = VEC[v][8];
            nx     = VEC[v][7:0];
            fill = 1'b1; @(negedge clk); fill = 1'b0;
            set_regs(c, b);
            base = wr_cnt;
            send_frame(len, dst, v, rdy1);
            padl = (len < 60) ? 60 : len;
            tot  = padl + 4;
            chk(cur_pg == nx, acc ? "R6 R8 next page" : "R2 cur_pg kept", cur_pg, nx);
            chk(rx_flag == acc, acc ? "R8 rx_flag" : "R2 rx_flag", rx_flag, acc);
            chk(wr_cnt - base == (acc ? tot : 0), acc ? "R4 write count" : "R11 write count",
                wr_cnt - base, acc ? tot : 0);
            if (acc) begin
                chk(rdy1 == 1'b0, "R10 busy in header", rdy1, 0);
                hexp[0] = 8'h01 | (dst[0] ? 8'h20 : 8'h00);
                hexp[1] = nx;
                hexp[2] = 8'(tot);
                hexp[3] = 8'(tot >> 8);
                a = c * 256;
                for (int j = 0; j < 4; j++) begin
                    chk(bmem[a[11:0]] == hexp[j], j == 0 ? "R5 status" : "R4 header",
                        bmem[a[11:0]], hexp[j]);
                    a = ring_inc(a);
                end
                for (int k = 0; k < padl; k++) begin
                    e = (k >= len) ? 8'h00 : ((k == 0) ? dst : pay(k, v));
                    chk(bmem[a[11:0]] == e, (k >= len) ? "R3 pad" : "R7 payload",
                        bmem[a[11:0]], e);
                    a = ring_inc(a);
                end
            end else if (len > 1) begin
                chk(rdy1 == 1'b1, "R11 drop consumes", rdy1, 1);
            end
        end

        // R9: sticky flag, then clear
        set_regs(8'h04, 8'h04);
        send_frame(64, 8'h00, 5, rdy1);
        repeat (5) @(negedge clk);
        chk(rx_flag == 1'b1, "R9 flag holds", rx_flag, 1);
        rx_clr = 1'b1; @(negedge clk); rx_clr = 1'b0;
        chk(rx_flag == 1'b0, "R9 flag cleared", rx_flag, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule